// File: doc/BRIEF.md
# Ticket-Ordered Hardware Lock

This block is one mutual-exclusion lock shared by a set of cores. It grants the lock in strict arrival order. A core that wants the lock raises its request line. The block then hands that core the next free ticket in one cycle. The allocation is atomic, so the core never has to retry. The block keeps two wrapping counters. The issue counter holds the next ticket to hand out. The serving counter holds the ticket that currently owns the lock. A core is granted the lock only when its stored ticket equals the serving counter.

A waiting core does not compare tickets on every cycle. Each core runs a small state machine with four states:

- `CS_IDLE`: the core has no ticket.
- `CS_CHECK`: the core compares its ticket with the serving counter once.
- `CS_SLEEP`: the ticket did not match, so the core waits for a wake event.
- `CS_HOLD`: the core owns the lock.

The transitions are:

- Idle to check, on a request (*take*).
- Check to hold, on a match (*win*).
- Check to sleep, on a mismatch (*doze*).
- Sleep to check, on the wake event (*wake*).
- Hold to idle, on a release (*drop*).

When the holder releases, the serving counter advances and a single wake pulse goes to every core at the same time. The new serving value is already visible in the cycle the pulse is high, so every sleeper that wakes compares against the updated value. A release from a core that does not hold the lock is ignored. It sets a sticky error flag instead.

Top module: `ticket_lock`

## Requirements
- R1: After reset every grant is low, the wake pulse and the error flag are low, and both ticket counters are zero, so the first ticket handed out is the serving one.
- R2: A request from an idle core is sampled at a clock edge. When the lock is free with no one queued, that core's grant is high after the following edge.
- R3: Requests from idle cores in the same cycle receive consecutive tickets with the lower core index first, and the grants follow that order.
- R4: Requests made in different cycles are granted in the order they arrived, regardless of core index.
- R5: At most one grant is high in any cycle.
- R6: A release pulse from the granted core is sampled at an edge. After that edge the grant is low and the wake output is high for exactly one cycle.
- R7: A sleeping core whose ticket becomes the serving ticket sees its grant high two edges after the release edge. A core that takes its ticket at the release edge and finds it serving is granted one edge later.
- R8: A release pulse from a core that is not granted changes no grant and produces no wake pulse, and the error output is high after that edge.
- R9: Tickets are log2(cores)+1 bits wide and wrap modulo that width. Grant order holds across the wrap.
- R10: The error output stays high until reset.
- R11: A request line is sampled only while its core is idle. Holding it high while waiting or while holding the lock takes no second ticket.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acq_req | input | NUM_CORES | Per-core acquire request, sampled while that core is idle |
| rel_pulse | input | NUM_CORES | Per-core release strobe, one cycle |
| acq_gnt | output | NUM_CORES | Per-core grant, high while that core owns the lock |
| wake_evt | output | 1 | One-cycle wake pulse shared by all cores |
| rel_err | output | 1 | Sticky flag for a release from a core that does not own the lock |

## Verification
Two functions can land on the same clock edge. One is a release from the holder. The other is either a fresh request or a waiter's single comparison. The bench drives both of these coincidences.

In the first case, a core takes its ticket on the very edge that frees the lock. In the second case, a waiter in its check state compares against the old serving value while the release is moving that value forward. The bench confirms that the waiter falls asleep and is then woken by the pulse rather than missing it. A behavioural model built on ticket numbers predicts the exact cycle each grant rises, and every grant, wake and error bit is compared against it on each clock.

// File: rtl/tlock_pkg.sv
package tlock_pkg;

    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_CHECK = 2'd1,
        CS_SLEEP = 2'd2,
        CS_HOLD  = 2'd3
    } core_state_e;

endpackage

// File: rtl/tlock_alloc.sv
// Same-cycle ticket allocator: lower core index gets the lower ticket.
module tlock_alloc #(
    parameter int N  = 4,
    parameter int TW = 3
) (
    input  logic [N-1:0]         take,
    input  logic [TW-1:0]        issue_q,
    output logic [N-1:0][TW-1:0] offer,
    output logic [TW-1:0]        total
);

    logic [TW-1:0] prefix [N+1];

    assign prefix[0] = '0;

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_prefix
            assign prefix[gi+1] = prefix[gi] + TW'(take[gi]);
            assign offer[gi]    = issue_q + prefix[gi];
        end
    endgenerate

    assign total = prefix[N];

endmodule

// File: rtl/tlock_core.sv
// Per-core state machine: holds the core's ticket and decides its grant.
module tlock_core
    import tlock_pkg::*;
#(
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          rel,
    input  logic [TW-1:0] offer,
    input  logic [TW-1:0] serving_q,
    input  logic          wake_q,
    output logic          take,
    output logic          hold,
    output logic          rel_hit,
    output logic          rel_miss
);

    core_state_e   state_q;
    core_state_e   state_d;
    logic [TW-1:0] ticket_q;

    // state register and ticket storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= CS_IDLE;
            ticket_q <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                ticket_q <= offer;
            end
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_IDLE:  if (req)                    state_d = CS_CHECK;
            CS_CHECK: if (ticket_q == serving_q)  state_d = CS_HOLD;
                      else                        state_d = CS_SLEEP;
            CS_SLEEP: if (wake_q)                 state_d = CS_CHECK;
            CS_HOLD:  if (rel)                    state_d = CS_IDLE;
            default:                              state_d = CS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        take     = 1'b0;
        hold     = 1'b0;
        rel_hit  = 1'b0;
        rel_miss = 1'b0;
        unique case (state_q)
            CS_IDLE: begin
                take     = req;
                rel_miss = rel;
            end
            CS_HOLD: begin
                hold    = 1'b1;
                rel_hit = rel;
            end
            default: begin
                rel_miss = rel;
            end
        endcase
    end

endmodule

// File: rtl/tlock_counters.sv
// Issue and serving counters, wake pulse and sticky error.
module tlock_counters #(
    parameter int N  = 4,
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] total,
    input  logic [N-1:0]  rel_hit,
    input  logic [N-1:0]  rel_miss,
    output logic [TW-1:0] issue_q,
    output logic [TW-1:0] serving_q,
    output logic          wake_q,
    output logic          err_q
);

    logic advance;
    logic misuse;

    assign advance = |rel_hit;
    assign misuse  = |rel_miss;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issue_q   <= '0;
            serving_q <= '0;
            wake_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            issue_q <= issue_q + total;
            if (advance) begin
                serving_q <= serving_q + TW'(1);
            end
            // pulse rises together with the new serving value
            wake_q <= advance;
            if (misuse) begin
                err_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ticket_lock.sv
module ticket_lock #(
    parameter int NUM_CORES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CORES-1:0] acq_req,
    input  logic [NUM_CORES-1:0] rel_pulse,
    output logic [NUM_CORES-1:0] acq_gnt,
    output logic                 wake_evt,
    output logic                 rel_err
);

    localparam int TW = $clog2(NUM_CORES) + 1;

    logic [NUM_CORES-1:0]         take;
    logic [NUM_CORES-1:0]         hold;
    logic [NUM_CORES-1:0]         rel_hit;
    logic [NUM_CORES-1:0]         rel_miss;
    logic [NUM_CORES-1:0][TW-1:0] offer;
    logic [TW-1:0]                total;
    logic [TW-1:0]                issue_q;
    logic [TW-1:0]                serving_q;
    logic                         wake_q;
    logic                         err_q;

    tlock_alloc #(.N(NUM_CORES), .TW(TW)) u_alloc (
        .take    (take),
        .issue_q (issue_q),
        .offer   (offer),
        .total   (total)
    );

    tlock_counters #(.N(NUM_CORES), .TW(TW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .total     (total),
        .rel_hit   (rel_hit),
        .rel_miss  (rel_miss),
        .issue_q   (issue_q),
        .serving_q (serving_q),
        .wake_q    (wake_q),
        .err_q     (err_q)
    );

    genvar gc;
    generate
        for (gc = 0; gc < NUM_CORES; gc++) begin : g_core
            tlock_core #(.TW(TW)) u_core (
                .clk       (clk),
                .rst_n     (rst_n),
                .req       (acq_req[gc]),
                .rel       (rel_pulse[gc]),
                .offer     (offer[gc]),
                .serving_q (serving_q),
                .wake_q    (wake_q),
                .take      (take[gc]),
                .hold      (hold[gc]),
                .rel_hit   (rel_hit[gc]),
                .rel_miss  (rel_miss[gc])
            );
        end
    endgenerate

    assign acq_gnt  = hold;
    assign wake_evt = wake_q;
    assign rel_err  = err_q;

endmodule

// File: rtl/ticket_lock_chk.sv
module ticket_lock_chk #(
    parameter int NUM_CORES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_CORES-1:0] acq_req,
    input logic [NUM_CORES-1:0] rel_pulse,
    input logic [NUM_CORES-1:0] acq_gnt,
    input logic                 wake_evt,
    input logic                 rel_err
);

    // R5
    mutex_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acq_gnt));

    // R6
    wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> !wake_evt);

    // R6
    wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_evt) |-> $past(|(rel_pulse & acq_gnt)));

    // R6
    drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rel_pulse & acq_gnt)) |=> ((acq_gnt & $past(rel_pulse)) == '0));

    // R8
    misuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rel_pulse & ~acq_gnt)) |=> rel_err);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_err |=> rel_err);

endmodule

bind ticket_lock ticket_lock_chk #(.NUM_CORES(NUM_CORES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acq_req   (acq_req),
    .rel_pulse (rel_pulse),
    .acq_gnt   (acq_gnt),
    .wake_evt  (wake_evt),
    .rel_err   (rel_err)
);

// File: tb/ticket_lock_bench.sv
`timescale 1ns/1ps
module ticket_lock_bench;

    localparam int N  = 4;
    localparam int TW = $clog2(N) + 1;
    localparam int M  = 1 << TW;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] acq_req = '0;
    logic [N-1:0] rel_pulse = '0;
    logic [N-1:0] acq_gnt;
    logic         wake_evt;
    logic         rel_err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ticket_lock #(.NUM_CORES(N)) u_ticket_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .acq_req   (acq_req),
        .rel_pulse (rel_pulse),
        .acq_gnt   (acq_gnt),
        .wake_evt  (wake_evt),
        .rel_err   (rel_err)
    );

    // behavioural reference: ticket numbers, a holder index, pending rechecks
    int mnext, mowner, mholder;
    int mtkt [N];
    bit mwait [N];
    bit mrecheck [N];
    bit mwake, merr;

    always @(posedge clk) begin
        if (!rst_n) begin
            mnext = 0; mowner = 0; mholder = -1; mwake = 0; merr = 0;
            for (int i = 0; i < N; i++) begin
                mtkt[i] = 0; mwait[i] = 0; mrecheck[i] = 0;
            end
        end else begin
            int  nh, nown;
            bit  nw, ne;
            bit  wv [N];
            bit  rc [N];
            nh = mholder; nown = mowner; nw = 0; ne = merr;
            for (int i = 0; i < N; i++) begin
                wv[i] = mwait[i]; rc[i] = mrecheck[i];
            end
            for (int i = 0; i < N; i++) begin
                if (rel_pulse[i]) begin
                    if (mholder == i) begin
                        nown = (mowner + 1) % M; nh = -1; nw = 1;
                    end else begin
                        ne = 1;
                    end
                end
            end
            for (int i = 0; i < N; i++) begin
                if (mwait[i]) begin
                    if (mrecheck[i]) begin
                        rc[i] = 0;
                        if (mtkt[i] == mowner) begin
                            wv[i] = 0; nh = i;
                        end
                    end else if (mwake) begin
                        rc[i] = 1;
                    end
                end
            end
            for (int i = 0; i < N; i++) begin
                if (acq_req[i] && !mwait[i] && mholder != i) begin
                    mtkt[i] = mnext; mnext = (mnext + 1) % M;
                    wv[i] = 1; rc[i] = 1;
                end
            end
            mholder = nh; mowner = nown; mwake = nw; merr = ne;
            for (int i = 0; i < N; i++) begin
                mwait[i] = wv[i]; mrecheck[i] = rc[i];
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // compare every cycle against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [N-1:0] eg;
            eg = '0;
            if (mholder >= 0) eg[mholder] = 1'b1;
            chk(acq_gnt == eg, "R4 grant vs model", int'(acq_gnt), int'(eg));
            chk(wake_evt == mwake, "R6 wake vs model", int'(wake_evt), int'(mwake));
            chk(rel_err == merr, "R8 error vs model", int'(rel_err), int'(merr));
            chk($countones(acq_gnt) <= 1, "R5 single grant", $countones(acq_gnt), 1);
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic request(input logic [N-1:0] m);
        acq_req = m; tick(); acq_req = '0;
    endtask

    task automatic release_core(input int i);
        rel_pulse = '0; rel_pulse[i] = 1'b1; tick(); rel_pulse = '0;
    endtask

    task automatic wait_any_gnt();
        int n;
        n = 0;
        while (acq_gnt == '0 && n < 50) begin tick(); n++; end
    endtask

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R1 reset state
        chk(acq_gnt == '0, "R1 grants", int'(acq_gnt), 0);
        chk(wake_evt == 0 && rel_err == 0, "R1 wake/err", int'({wake_evt, rel_err}), 0);
        rst_n = 1'b1;
        tick();

        // R2 uncontended latency
        request(4'b0100);
        chk(acq_gnt == '0, "R2 no grant after sample edge", int'(acq_gnt), 0);
        tick();
        chk(acq_gnt == 4'b0100, "R2 grant after next edge", int'(acq_gnt), 4);
        // R11 held request while holding takes no extra ticket
        acq_req = 4'b0100; repeat (3) tick(); acq_req = '0;
        // R6 release pulse
        release_core(2);
        chk(acq_gnt == '0, "R6 grant dropped", int'(acq_gnt), 0);
        chk(wake_evt == 1, "R6 wake high", int'(wake_evt), 1);
        tick();
        chk(wake_evt == 0, "R6 wake one cycle", int'(wake_evt), 0);
        chk(acq_gnt == '0, "R11 no re-grant from held request", int'(acq_gnt), 0);

        // R3 simultaneous requests in index order
        request(4'b1111);
        for (int k = 0; k < N; k++) begin
            wait_any_gnt();
            chk(acq_gnt == (4'b1 << k), "R3 same-cycle order", int'(acq_gnt), 1 << k);
            repeat (2) tick();
            release_core(k);
        end
        repeat (4) tick();

        // R4 arrival order across cycles; R7 sleeper timing
        request(4'b0100); tick();
        request(4'b1000); request(4'b0010); request(4'b0001);
        repeat (4) tick();
        release_core(2);
        chk(acq_gnt == '0, "R7 sleeper not yet granted", int'(acq_gnt), 0);
        tick();
        chk(acq_gnt == '0, "R7 sleeper rechecking", int'(acq_gnt), 0);
        tick();
        chk(acq_gnt == 4'b1000, "R7 sleeper granted two edges later", int'(acq_gnt), 8);
        release_core(3);
        wait_any_gnt();
        chk(acq_gnt == 4'b0010, "R4 second arrival", int'(acq_gnt), 2);
        release_core(1);
        wait_any_gnt();
        chk(acq_gnt == 4'b0001, "R4 third arrival", int'(acq_gnt), 1);

        // release and new request on the same edge
        rel_pulse = 4'b0001; acq_req = 4'b1000; tick();
        rel_pulse = '0; acq_req = '0;
        chk(acq_gnt == '0, "R7 same-edge taker waits one edge", int'(acq_gnt), 0);
        tick();
        chk(acq_gnt == 4'b1000, "R7 same-edge taker granted", int'(acq_gnt), 8);

        // R8 release from non-holder
        release_core(1);
        chk(acq_gnt == 4'b1000, "R8 grant unchanged", int'(acq_gnt), 8);
        chk(wake_evt == 0, "R8 no wake", int'(wake_evt), 0);
        chk(rel_err == 1, "R8 error set", int'(rel_err), 1);
        release_core(3);
        repeat (3) tick();

        // R9 wrap: many rounds cross the ticket width
        for (int r = 0; r < 6; r++) begin
            request(4'b1111);
            for (int k = 0; k < N; k++) begin
                wait_any_gnt();
                chk(acq_gnt == (4'b1 << k), "R9 order across wrap", int'(acq_gnt), 1 << k);
                release_core(k);
            end
        end
        repeat (3) tick();
        chk(rel_err == 1, "R10 error still set", int'(rel_err), 1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule